// File: doc/BRIEF.md
# Four-Output Power Sequencer

This controller drives four enable lines, numbered 0 to 3, that switch downstream supply regulators on and off in a fixed order. It watches a single supply-compliance flag and a sequence-enable request. When the supply is compliant and the request is active, it waits a programmable start delay, turns on output 0, and then turns on outputs 1, 2 and 3. Each of these later steps waits for its own programmable delay. All delays are counted in clock cycles.

When the request is withdrawn, the controller runs the start delay again and then turns the outputs off from 3 down to 0. This off-sequence reuses the stage delays in mirrored order. If compliance is lost, all outputs return to their reset level at the next clock edge, whatever the controller was doing.

Parameters set three options: the polarity of the outputs, the polarity of the request input, and whether the request input exists at all. Without it, compliance alone starts the sequence. The sequence-enable request passes through a two-flop synchronizer. The compliance flag is taken as already synchronous to the clock.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is held, every output is at its reset level, `busy` is 0 and `state_o` is 0.
- R2: Sequencing starts only when `comp_ok` is 1 and the synchronized request is active. If the request is first sampled active at clock edge 1, output 0 turns on at edge `start_dly`+4.
- R3: Outputs turn on strictly in the order 0, 1, 2, 3.
  - Output 1 turns on `dly_b`+1 edges after output 0.
  - Output 2 turns on `dly_c`+1 edges after output 1.
  - Output 3 turns on `dly_d`+1 edges after output 2.
  - A delay of zero therefore gives one edge.
- R4: A compliance loss during the start delay aborts start-up and clears the timer. If compliance returns at edge 1 with the request active, output 0 turns on at edge `start_dly`+2.
- R5: After the request is withdrawn from the all-on state, outputs turn off in the order 3, 2, 1, 0.
  - Output 3 turns off at edge `start_dly`+4, counted as in R2.
  - Output 2 turns off `dly_d`+1 edges after output 3.
  - Output 1 turns off `dly_c`+1 edges after output 2.
  - Output 0 turns off `dly_b`+1 edges after output 1.
- R6: At the first clock edge that samples `comp_ok` at 0, all four outputs return to their reset level together and `state_o` becomes 0. This holds from any state.
- R7: If the request is reasserted during an off-sequence, the start delay runs again. The controller then turns outputs back on, starting from the lowest output that is off. Outputs that are still on stay on.
- R8: With `OUT_ACT_LOW`=0 the reset level of each output is 0. With `OUT_ACT_LOW`=1 it is 1 and an active output reads 0.
- R9: With `HAS_SEQ_EN`=0, `seq_en_in` is ignored. If `comp_ok` is first sampled 1 at edge 1, output 0 turns on at edge `start_dly`+2. In this variant, outputs turn off only on a compliance loss.
- R10: `state_o` encodes 0 idle, 1 start delay, 2 turning on, 3 all on, 4 off delay, 5 turning off.
  - `busy` is 1 in states 1, 2, 4 and 5 and 0 otherwise.
  - In state 3 all outputs are active. In state 0 none are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| comp_ok | input | 1 | Supply within limits (synchronous) |
| seq_en_in | input | 1 | Sequence request, asynchronous, polarity set by `SEQ_ACT_LOW` |
| start_dly | input | DLY_W | Start and off-start delay, in cycles |
| dly_b | input | DLY_W | Stage delay before output 1 on / output 0 off |
| dly_c | input | DLY_W | Stage delay before output 2 on / output 1 off |
| dly_d | input | DLY_W | Stage delay before output 3 on / output 2 off |
| en_out | output | 4 | Sequenced enables, bit i is output i |
| busy | output | 1 | A timed step is in progress |
| state_o | output | 3 | Controller state code |

## Verification
A compliance loss can fall in the very cycle in which a stage timer expires. The fault has to win, so no output may step up or down on that edge. The bench provokes this by dropping `comp_ok` both in the middle of the start delay and after the full ramp. It judges the outcome from the cycle at which output 0 next rises: that edge shows the timer was cleared rather than resumed. A second overlap puts a request reassertion against a pending turn-off step. The bench raises the request right after output 2 drops, with a stage delay longer than the synchronizer path. It then expects outputs 0 and 1 never to fall, and output 2 to return after a full start delay.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_RAMP  = 3'd2,
    ST_FULL  = 3'd3,
    ST_HOLD  = 3'd4,
    ST_DRAIN = 3'd5
  } seq_state_e;

  // thermometer decode: the lowest 'lvl' outputs are on
  function automatic logic [3:0] level_mask(input logic [2:0] lvl);
    logic [3:0] m;
    for (int i = 0; i < 4; i++) m[i] = (3'(i) < lvl);
    return m;
  endfunction

endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (!(&cnt_q))    cnt_q <= cnt_q + W'(1);
  end

  assign expired = (cnt_q == limit);
endmodule

// File: rtl/seq_outdrv.sv
module seq_outdrv #(
  parameter int LANES   = 4,
  parameter bit ACT_LOW = 1'b0
) (
  input  logic [LANES-1:0] on_mask,
  output logic [LANES-1:0] pins
);
  generate
    if (ACT_LOW) begin : g_low
      assign pins = ~on_mask;
    end else begin : g_high
      assign pins = on_mask;
    end
  endgenerate
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int DLY_W       = 16,
  parameter bit OUT_ACT_LOW = 1'b0,
  parameter bit HAS_SEQ_EN  = 1'b1,
  parameter bit SEQ_ACT_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             comp_ok,
  input  logic             seq_en_in,
  input  logic [DLY_W-1:0] start_dly,
  input  logic [DLY_W-1:0] dly_b,
  input  logic [DLY_W-1:0] dly_c,
  input  logic [DLY_W-1:0] dly_d,
  output logic [3:0]       en_out,
  output logic             busy,
  output logic [2:0]       state_o
);
  import seq_pkg::*;

  localparam int NOUT  = 4;
  localparam int LVL_W = $clog2(NOUT + 1);
  localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);
  localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(NOUT - 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(NOUT);

  seq_state_e       st_q, st_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             go;
  logic             tmr_restart, tmr_done;
  logic [DLY_W-1:0] tmr_limit;
  logic [NOUT-1:0]  on_mask;

  // the stage delay is chosen by how many outputs are on; the same choice
  // serves turning the next one on and turning the top one off
  function automatic logic [DLY_W-1:0] stage_delay(input logic [LVL_W-1:0] lvl,
                                                   input logic [DLY_W-1:0] db,
                                                   input logic [DLY_W-1:0] dc,
                                                   input logic [DLY_W-1:0] dd);
    case (lvl)
      LVL_W'(2): return dc;
      LVL_W'(3): return dd;
      default:   return db;
    endcase
  endfunction

  generate
    if (HAS_SEQ_EN) begin : g_req
      logic req_sync;
      seq_sync #(.RST_VAL(SEQ_ACT_LOW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (seq_en_in),
        .q     (req_sync)
      );
      assign go = req_sync ^ SEQ_ACT_LOW;
    end else begin : g_noreq
      logic req_unused;
      assign req_unused = seq_en_in;
      assign go = 1'b1;
    end
  endgenerate

  always_comb begin
    st_d  = st_q;
    lvl_d = lvl_q;
    if (!comp_ok) begin
      st_d  = ST_IDLE;
      lvl_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: if (go) st_d = ST_START;
        ST_START: begin
          if (!go) st_d = (lvl_q == '0) ? ST_IDLE : ST_HOLD;
          else if (tmr_done) begin
            lvl_d = lvl_q + LVL_ONE;
            st_d  = (lvl_q == LVL_TOP) ? ST_FULL : ST_RAMP;
          end
        end
        ST_RAMP: begin
          if (!go) st_d = ST_HOLD;
          else if (tmr_done) begin
            lvl_d = lvl_q + LVL_ONE;
            st_d  = (lvl_q == LVL_TOP) ? ST_FULL : ST_RAMP;
          end
        end
        ST_FULL: if (!go) st_d = ST_HOLD;
        ST_HOLD: begin
          if (go) st_d = (lvl_q == LVL_FULL) ? ST_FULL : ST_START;
          else if (tmr_done) begin
            lvl_d = lvl_q - LVL_ONE;
            st_d  = (lvl_q == LVL_ONE) ? ST_IDLE : ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (go) st_d = ST_START;
          else if (tmr_done) begin
            lvl_d = lvl_q - LVL_ONE;
            st_d  = (lvl_q == LVL_ONE) ? ST_IDLE : ST_DRAIN;
          end
        end
        default: begin
          st_d  = ST_IDLE;
          lvl_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      lvl_q <= '0;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
    end
  end

  assign tmr_limit   = (st_q == ST_START || st_q == ST_HOLD) ? start_dly
                     : stage_delay(lvl_q, dly_b, dly_c, dly_d);
  assign tmr_restart = (st_d != st_q) || (lvl_d != lvl_q)
                     || (st_q == ST_IDLE) || (st_q == ST_FULL);

  seq_timer #(.W(DLY_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .limit   (tmr_limit),
    .expired (tmr_done)
  );

  assign on_mask = level_mask(lvl_q);

  seq_outdrv #(.LANES(NOUT), .ACT_LOW(OUT_ACT_LOW)) u_drv (
    .on_mask (on_mask),
    .pins    (en_out)
  );

  assign state_o = st_q;
  assign busy    = st_q inside {ST_START, ST_RAMP, ST_HOLD, ST_DRAIN};
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       comp_ok,
  input logic [2:0] state_o,
  input logic [3:0] on_mask,
  input logic       busy
);
  logic [3:0] prev_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_mask <= 4'h0;
    else        prev_mask <= on_mask;
  end

  // R6
  fault_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !comp_ok |=> (on_mask == 4'h0 && state_o == 3'd0));

  // R3
  thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_mask inside {4'h0, 4'h1, 4'h3, 4'h7, 4'hF});

  // R5
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_mask == prev_mask) || (on_mask == {prev_mask[2:0], 1'b1})
    || (on_mask == {1'b0, prev_mask[3:1]}) || (on_mask == 4'h0));

  // R2
  first_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_mask[0]) |-> $past(state_o) == 3'd1);

  // R10
  full_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd3 |-> (on_mask == 4'hF && !busy));

  // R10
  idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd0 |-> (on_mask == 4'h0 && !busy));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .comp_ok (comp_ok),
  .state_o (state_o),
  .on_mask (on_mask),
  .busy    (busy)
);

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        comp0, seq0, comp1, seq1;
  logic [15:0] s0, b0, c0, d0;
  logic [3:0]  en0, en1;
  logic        busy0, busy1;
  logic [2:0]  st0, st1;

  pwr_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .comp_ok(comp0), .seq_en_in(seq0),
    .start_dly(s0), .dly_b(b0), .dly_c(c0), .dly_d(d0),
    .en_out(en0), .busy(busy0), .state_o(st0));

  pwr_seq_ctrl #(.OUT_ACT_LOW(1'b1), .HAS_SEQ_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .comp_ok(comp1), .seq_en_in(seq1),
    .start_dly(16'd2), .dly_b(16'd1), .dly_c(16'd1), .dly_d(16'd1),
    .en_out(en1), .busy(busy1), .state_o(st1));

  int n_chk = 0;
  int n_bad = 0;
  int tm [4];

  // rows {start, b, c, d}, one byte each
  localparam logic [31:0] VEC [4] = '{32'h00000000, 32'h03010205,
                                      32'h07040002, 32'h01060300};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // first negedge index (edges since the drive) at which each bit equals want
  task automatic watch(input logic [3:0] want);
    for (int i = 0; i < 4; i++) tm[i] = -1;
    for (int n = 1; n <= 600; n++) begin
      bit all;
      @(negedge clk);
      all = 1'b1;
      for (int i = 0; i < 4; i++) begin
        if (tm[i] < 0 && en0[i] == want[i]) tm[i] = n;
        if (tm[i] < 0) all = 1'b0;
      end
      if (all) break;
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    report();
  end

  initial begin
    rst_n = 1'b0; comp0 = 1'b0; seq0 = 1'b0; comp1 = 1'b0; seq1 = 1'b0;
    s0 = '0; b0 = '0; c0 = '0; d0 = '0;
    step(3);
    chk("R1 en_out", en0, 0);
    chk("R1 busy", busy0, 0);
    chk("R1 state", st0, 0);
    chk("R8 active-low reset level", en1, 15);
    rst_n = 1'b1;
    step(2);

    comp0 = 1'b1;
    step(4);
    chk("R2 no start without request", en0, 0);

    for (int r = 0; r < 4; r++) begin
      int s, b, c, d, ea, eb, ec, ed;
      s = int'(VEC[r][31:24]); b = int'(VEC[r][23:16]);
      c = int'(VEC[r][15:8]);  d = int'(VEC[r][7:0]);
      s0 = 16'(s); b0 = 16'(b); c0 = 16'(c); d0 = 16'(d);
      step(1);
      seq0 = 1'b1;
      watch(4'hF);
      ea = 4 + s; eb = ea + b + 1; ec = eb + c + 1; ed = ec + d + 1;
      chk("R2 output 0 on", tm[0], ea);
      chk("R3 output 1 on", tm[1], eb);
      chk("R3 output 2 on", tm[2], ec);
      chk("R3 output 3 on", tm[3], ed);
      step(2);
      chk("R10 all-on state", st0, 3);
      chk("R10 all-on busy", busy0, 0);
      seq0 = 1'b0;
      watch(4'h0);
      ed = 4 + s; ec = ed + d + 1; eb = ec + c + 1; ea = eb + b + 1;
      chk("R5 output 3 off", tm[3], ed);
      chk("R5 output 2 off", tm[2], ec);
      chk("R5 output 1 off", tm[1], eb);
      chk("R5 output 0 off", tm[0], ea);
      step(2);
      chk("R10 idle state", st0, 0);
    end

    // R4: fault in the middle of the start delay
    s0 = 16'd10; b0 = 16'd1; c0 = 16'd1; d0 = 16'd1;
    seq0 = 1'b1;
    step(6);
    chk("R10 start-delay state", st0, 1);
    chk("R10 start-delay busy", busy0, 1);
    comp0 = 1'b0;
    step(1);
    chk("R4 aborted outputs", en0, 0);
    chk("R4 aborted state", st0, 0);
    comp0 = 1'b1;
    watch(4'hF);
    chk("R4 full start delay rerun", tm[0], 12);
    chk("R4 next stage", tm[1], 14);

    // R6: fault after complete ramp
    step(2);
    comp0 = 1'b0;
    step(1);
    chk("R6 all off in one edge", en0, 0);
    chk("R6 state idle", st0, 0);
    comp0 = 1'b1;
    watch(4'hF);
    chk("R6 recovery output 3", tm[3], 18);

    // R7: request back during the off-sequence
    s0 = 16'd2; b0 = 16'd3; c0 = 16'd3; d0 = 16'd3;
    step(2);
    seq0 = 1'b0;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if (en0 == 4'h3) break;
    end
    chk("R7 two outputs left", en0, 3);
    seq0 = 1'b1;
    watch(4'hF);
    chk("R7 output 0 kept", tm[0], 1);
    chk("R7 output 1 kept", tm[1], 1);
    chk("R7 output 2 back", tm[2], 6);
    chk("R7 output 3 back", tm[3], 10);
    chk("R7 output 1 never dropped", en0[1], 1);

    // R9 / R8: variant without request input, active-low outputs
    comp1 = 1'b1;
    step(3);
    chk("R9 nothing yet", en1, 15);
    step(1);
    chk("R9 output 0 on from compliance", en1, 14);
    step(6);
    chk("R8 all active reads zero", en1, 0);
    seq1 = 1'b1;
    step(5);
    seq1 = 1'b0;
    step(5);
    chk("R9 request ignored", en1, 0);
    chk("R9 state all-on", st1, 3);
    comp1 = 1'b0;
    step(1);
    chk("R6 variant fault", en1, 15);

    report();
  end
endmodule